// File: doc/BRIEF.md
# DDR2 Bank Timing Guard

This block watches the command stream that a DDR2 memory controller sends to one SDRAM device. It follows each of the eight banks through its idle and row-open states. For every bank it tells the controller, one flag per command type, whether that command may go out in the current cycle. The block issues no commands of its own. It checks the row-timing rules, and a one-cycle error pulse marks any command that breaks them.

Each timing limit is a fixed time in picoseconds, set by a parameter. The block turns the limits into clock counts by ceiling division by the clock period, which the `tck_ps` input supplies in picoseconds. One command may be presented per cycle. The controller connects its address bit 10 to `addr_ap`. On a precharge, that line chooses between closing every bank and closing only the addressed bank. A command that breaks a rule is reported and then discarded, so the bank state stays as it was before the command.

Top module: `ddr2_bank_guard`

## Requirements
- R1: After reset every bank is idle with all timers expired: `act_ok` is all ones, `col_ok` is all zeros, `pre_ok` is all ones, `ref_ok` is 1 and `err` is 0.
- R2: An accepted activate (cmd 1) to a bank in cycle t holds that bank's `col_ok` low until cycle t+N, where N = ceil(TRCD_PS/tck_ps). `col_ok` rises in cycle t+N and stays high while the row is open.
- R3: After an accepted activate in cycle t, the bank's `pre_ok` stays low until cycle t+ceil(TRAS_PS/tck_ps). A bank with no open row always shows `pre_ok` high.
- R4: A precharge that closes an open row in cycle t holds that bank's `act_ok` low until cycle t+ceil(TRP_PS/tck_ps).
- R5: After an accepted activate in cycle t, the bank's `act_ok` stays low until cycle t+ceil(TRC_PS/tck_ps), even if the row was closed sooner. `act_ok` is high only for an idle bank whose precharge and row-cycle times have both run out.
- R6: A read (cmd 2) or write (cmd 3) is illegal when the bank's `col_ok` is low, which covers a bank with no open row. It raises `err` in the cycle that follows.
- R7: An activate is illegal when the bank's `act_ok` is low, which covers a bank whose row is already open. It raises `err` in the cycle that follows.
- R8: A precharge (cmd 4) with `addr_ap`=1 closes every open bank and is legal only when all eight `pre_ok` flags are high. With `addr_ap`=0 it closes only the addressed bank and is legal when that bank's `pre_ok` is high.
- R9: A precharge to a bank with no open row is legal and has no effect on that bank. In particular it does not restart the bank's precharge timer.
- R10: `ref_ok` is high only when every bank is idle and its precharge time has run out. A refresh (cmd 5) issued while `ref_ok` is low raises `err` in the cycle that follows.
- R11: An illegal command changes no bank state: no row opens or closes, and no timer restarts.
- R12: Each limit in cycles is ceil(limit_ps/tck_ps). The result saturates at 2^CNT_W-1, and a `tck_ps` of 0 also gives that maximum.
- R13: `err` is registered and lasts one cycle per illegal command. A no-operation (cmd 0, 6 or 7) is never an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command: 0 none, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 and 7 none |
| bank | input | BANK_W (3) | Bank address of the command |
| addr_ap | input | 1 | Address bit 10; on a precharge, 1 means all banks |
| tck_ps | input | TCK_W (16) | Clock period in picoseconds |
| act_ok | output | 8 | Per bank: activate allowed this cycle |
| col_ok | output | 8 | Per bank: read or write allowed this cycle |
| pre_ok | output | 8 | Per bank: precharge allowed this cycle |
| ref_ok | output | 1 | Refresh allowed this cycle |
| err | output | 1 | Pulse one cycle after an illegal command |

## Verification
The bench targets these off-by-one edges:
- Column access one cycle before and exactly at the activate-to-column limit. A guard that loaded its counters one count too long or too short would flag the legal read, or let the early one through.
- Row cycles at a period long enough that a limit comes to a single clock.
- A period short enough that the counts saturate.
- Precharge-all while one bank is still inside its minimum row-open time. A design that tested only the addressed bank would close the rows without reporting the error.
- Precharges to idle banks and repeated activates to an open bank. A design that let illegal or void commands reload timers would show `col_ok` or `act_ok` dropping afterwards.

// File: rtl/ddr2_guard_pkg.sv
package ddr2_guard_pkg;
   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_PRE = 3'd4,
      CMD_REF = 3'd5
   } ddr2_cmd_e;

   localparam int LIM_RCD = 0;
   localparam int LIM_RAS = 1;
   localparam int LIM_RP  = 2;
   localparam int LIM_RC  = 3;
   localparam int NUM_LIM = 4;
endpackage

// File: rtl/ddr2_cyc_limit.sv
module ddr2_cyc_limit #(
   parameter int LIMIT_PS = 12500,
   parameter int TCK_W    = 16,
   parameter int CNT_W    = 6
) (
   input  logic [TCK_W-1:0] tck_ps,
   output logic [CNT_W-1:0] cycles
);
   localparam int PS_W  = $clog2(LIMIT_PS + 1);
   localparam int SUM_W = ((PS_W > TCK_W) ? PS_W : TCK_W) + 1;
   localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

   if (LIMIT_PS < 1) begin : g_bad_limit
      $error("ddr2_cyc_limit: LIMIT_PS must be positive");
   end

   logic [SUM_W-1:0] num;
   logic [SUM_W-1:0] quo;

   always_comb begin
      num = SUM_W'(LIMIT_PS) + SUM_W'(tck_ps) - SUM_W'(1);
      quo = (tck_ps == '0) ? '1 : num / SUM_W'(tck_ps);
   end

   if (SUM_W > CNT_W) begin : g_sat
      assign cycles = (quo > SUM_W'(MAXC)) ? MAXC : quo[CNT_W-1:0];
   end else begin : g_wide
      assign cycles = (tck_ps == '0) ? MAXC : CNT_W'(quo);
   end
endmodule

// File: rtl/ddr2_bank_timer.sv
module ddr2_bank_timer #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_go,
   input  logic             pre_go,
   input  logic [CNT_W-1:0] n_rcd,
   input  logic [CNT_W-1:0] n_ras,
   input  logic [CNT_W-1:0] n_rp,
   input  logic [CNT_W-1:0] n_rc,
   output logic             act_ok,
   output logic             col_ok,
   output logic             pre_ok,
   output logic             idle_ok
);
   logic             open_q;
   logic [CNT_W-1:0] rcd_q, ras_q, rp_q, rc_q;

   function automatic logic [CNT_W-1:0] dec_sat(input logic [CNT_W-1:0] v);
      return (v == '0) ? v : v - CNT_W'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         rcd_q  <= '0;
         ras_q  <= '0;
         rp_q   <= '0;
         rc_q   <= '0;
      end else begin
         if (act_go)      open_q <= 1'b1;
         else if (pre_go) open_q <= 1'b0;
         rcd_q <= act_go ? n_rcd - CNT_W'(1) : dec_sat(rcd_q);
         ras_q <= act_go ? n_ras - CNT_W'(1) : dec_sat(ras_q);
         rc_q  <= act_go ? n_rc  - CNT_W'(1) : dec_sat(rc_q);
         rp_q  <= (pre_go && open_q) ? n_rp - CNT_W'(1) : dec_sat(rp_q);
      end
   end

   assign act_ok  = !open_q && (rp_q == '0) && (rc_q == '0);
   assign col_ok  = open_q && (rcd_q == '0);
   assign pre_ok  = !open_q || (ras_q == '0);
   assign idle_ok = !open_q && (rp_q == '0);
endmodule

// File: rtl/ddr2_bank_guard.sv
module ddr2_bank_guard
   import ddr2_guard_pkg::*;
#(
   parameter int BANK_W  = 3,
   parameter int TCK_W   = 16,
   parameter int CNT_W   = 6,
   parameter int TRCD_PS = 12500,
   parameter int TRAS_PS = 40000,
   parameter int TRP_PS  = 12500,
   parameter int TRC_PS  = 55000,
   localparam int NB     = 1 << BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cmd,
   input  logic [BANK_W-1:0] bank,
   input  logic              addr_ap,
   input  logic [TCK_W-1:0]  tck_ps,
   output logic [NB-1:0]     act_ok,
   output logic [NB-1:0]     col_ok,
   output logic [NB-1:0]     pre_ok,
   output logic              ref_ok,
   output logic              err
);
   localparam int LIM_PS [NUM_LIM] = '{TRCD_PS, TRAS_PS, TRP_PS, TRC_PS};

   if (BANK_W < 1 || BANK_W > 4) begin : g_bad_bank
      $error("ddr2_bank_guard: BANK_W out of range");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("ddr2_bank_guard: CNT_W too small");
   end

   logic [CNT_W-1:0] lim [NUM_LIM];
   logic [NB-1:0]    idle_ok, act_go, pre_go;
   logic             legal;
   logic             err_q;

   for (genvar i = 0; i < NUM_LIM; i++) begin : g_lim
      ddr2_cyc_limit #(
         .LIMIT_PS (LIM_PS[i]),
         .TCK_W    (TCK_W),
         .CNT_W    (CNT_W)
      ) u_lim (
         .tck_ps (tck_ps),
         .cycles (lim[i])
      );
   end

   always_comb begin
      case (cmd)
         CMD_ACT:        legal = act_ok[bank];
         CMD_RD, CMD_WR: legal = col_ok[bank];
         CMD_PRE:        legal = addr_ap ? (&pre_ok) : pre_ok[bank];
         CMD_REF:        legal = ref_ok;
         default:        legal = 1'b1;
      endcase
   end

   for (genvar b = 0; b < NB; b++) begin : g_bank
      assign act_go[b] = legal && (cmd == CMD_ACT) && (bank == BANK_W'(b));
      assign pre_go[b] = legal && (cmd == CMD_PRE) && (addr_ap || (bank == BANK_W'(b)));

      ddr2_bank_timer #(.CNT_W(CNT_W)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .act_go  (act_go[b]),
         .pre_go  (pre_go[b]),
         .n_rcd   (lim[LIM_RCD]),
         .n_ras   (lim[LIM_RAS]),
         .n_rp    (lim[LIM_RP]),
         .n_rc    (lim[LIM_RC]),
         .act_ok  (act_ok[b]),
         .col_ok  (col_ok[b]),
         .pre_ok  (pre_ok[b]),
         .idle_ok (idle_ok[b])
      );
   end

   assign ref_ok = &idle_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= !legal;
   end

   assign err = err_q;
endmodule

// File: rtl/ddr2_bank_guard_chk.sv
module ddr2_bank_guard_chk #(
   parameter int BANK_W = 3,
   parameter int NB     = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        cmd,
   input logic [BANK_W-1:0] bank,
   input logic              addr_ap,
   input logic [NB-1:0]     act_ok,
   input logic [NB-1:0]     col_ok,
   input logic [NB-1:0]     pre_ok,
   input logic              ref_ok,
   input logic              err
);
   p_nop_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd0 || cmd == 3'd6 || cmd == 3'd7) |=> !err);

   p_col_illegal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd == 3'd2 || cmd == 3'd3) && !col_ok[bank]) |=> err);

   p_act_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd1 && act_ok[bank]) |=> (!act_ok[$past(bank)] && !err));

   p_act_col_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (act_ok & col_ok) == '0);

   p_ref_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ref_ok |-> (col_ok == '0));

   p_pre_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd4 && addr_ap && (&pre_ok)) |=> (col_ok == '0 && !err));
endmodule

bind ddr2_bank_guard ddr2_bank_guard_chk #(.BANK_W(BANK_W), .NB(NB)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cmd     (cmd),
   .bank    (bank),
   .addr_ap (addr_ap),
   .act_ok  (act_ok),
   .col_ok  (col_ok),
   .pre_ok  (pre_ok),
   .ref_ok  (ref_ok),
   .err     (err)
);

// File: tb/ddr2_bank_guard_test.sv
`timescale 1ns/1ps
module ddr2_bank_guard_test;
   localparam int TRCD = 12500, TRAS = 40000, TRP = 12500, TRC = 55000;
   localparam int CMAX = 63;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cmd = 3'd0;
   logic [2:0]  bank = 3'd0;
   logic        addr_ap = 1'b0;
   logic [15:0] tck_ps = 16'd2500;
   logic [7:0]  act_ok, col_ok, pre_ok;
   logic        ref_ok, err;

   int n_chk = 0, n_fail = 0;
   int cyc = 0;
   bit mo [8];
   int rcd_r [8], ras_r [8], rp_r [8], rc_r [8];
   bit pend_err = 0;
   string err_tag = "R13";

   always #2.5 clk = ~clk;

   ddr2_bank_guard uut (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .addr_ap(addr_ap),
      .tck_ps(tck_ps), .act_ok(act_ok), .col_ok(col_ok), .pre_ok(pre_ok),
      .ref_ok(ref_ok), .err(err)
   );

   function automatic int ncyc(input int ps, input int t);
      int q;
      if (t == 0) return CMAX;
      q = (ps + t - 1) / t;
      return (q > CMAX) ? CMAX : q;
   endfunction

   function automatic logic [7:0] exp_act();
      for (int b = 0; b < 8; b++)
         exp_act[b] = !mo[b] && cyc >= rp_r[b] && cyc >= rc_r[b];
   endfunction
   function automatic logic [7:0] exp_col();
      for (int b = 0; b < 8; b++) exp_col[b] = mo[b] && cyc >= rcd_r[b];
   endfunction
   function automatic logic [7:0] exp_pre();
      for (int b = 0; b < 8; b++) exp_pre[b] = !mo[b] || cyc >= ras_r[b];
   endfunction
   function automatic logic exp_ref();
      exp_ref = 1'b1;
      for (int b = 0; b < 8; b++) if (mo[b] || cyc < rp_r[b]) exp_ref = 1'b0;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, act, exp);
      end
   endtask

   task automatic step(input logic [2:0] c, input int b, input bit ap);
      bit lg;
      logic [7:0] pv;
      @(negedge clk);
      chk("R5", act_ok, exp_act());
      chk("R2", col_ok, exp_col());
      chk("R3", pre_ok, exp_pre());
      chk("R10", ref_ok, exp_ref());
      chk(err_tag, err, pend_err);
      pv = exp_pre();
      case (c)
         3'd1: begin lg = exp_act()[b]; err_tag = "R7"; end
         3'd2, 3'd3: begin lg = exp_col()[b]; err_tag = "R6"; end
         3'd4: begin lg = ap ? (&pv) : pv[b]; err_tag = "R8"; end
         3'd5: begin lg = exp_ref(); err_tag = "R10"; end
         default: begin lg = 1'b1; err_tag = "R13"; end
      endcase
      pend_err = !lg;
      if (lg && c == 3'd1) begin
         mo[b] = 1;
         rcd_r[b] = cyc + ncyc(TRCD, tck_ps);
         ras_r[b] = cyc + ncyc(TRAS, tck_ps);
         rc_r[b]  = cyc + ncyc(TRC, tck_ps);
      end
      if (lg && c == 3'd4) begin
         for (int k = 0; k < 8; k++)
            if ((ap || k == b) && mo[k]) begin
               mo[k] = 0;
               rp_r[k] = cyc + ncyc(TRP, tck_ps);
            end
      end
      cmd = c; bank = 3'(b); addr_ap = ap;
      @(posedge clk);
      cyc++;
      #1;
      cmd = 3'd0; addr_ap = 1'b0;
   endtask

   task automatic nops(input int n);
      repeat (n) step(3'd0, 0, 0);
   endtask

   initial begin
      #1000000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int tcks [6] = '{2500, 3000, 3750, 5000, 8000, 20000};
      void'($urandom(32'h5eed_2d2));
      for (int b = 0; b < 8; b++) begin
         mo[b] = 0; rcd_r[b] = 0; ras_r[b] = 0; rp_r[b] = 0; rc_r[b] = 0;
      end
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1", act_ok, 8'hFF);
      chk("R1", col_ok, 8'h00);
      chk("R1", pre_ok, 8'hFF);
      chk("R1", ref_ok, 1'b1);
      chk("R1", err, 1'b0);

      // tck 2500: rcd 5, ras 16, rp 5, rc 22
      step(3'd1, 0, 0);
      nops(3);
      step(3'd2, 0, 0);               // one cycle early for tRCD
      chk("R6", err, 1'b1);
      step(3'd3, 0, 0);               // exactly at tRCD
      chk("R13", err, 1'b0);
      nops(6);
      step(3'd1, 0, 0);               // activate to open row
      chk("R7", err, 1'b1);
      chk("R11", col_ok[0], 1'b1);
      step(3'd5, 0, 0);
      chk("R10", err, 1'b1);
      step(3'd2, 4, 0);               // read to idle bank
      chk("R6", err, 1'b1);
      step(3'd1, 5, 0);
      step(3'd4, 0, 1);               // precharge-all with bank 5 inside tRAS
      chk("R8", err, 1'b1);
      chk("R11", col_ok[0], 1'b1);
      nops(20);
      step(3'd4, 0, 0);               // close only bank 0
      chk("R8", col_ok[5], 1'b1);
      chk("R4", act_ok[0], 1'b0);
      nops(3);
      chk("R4", act_ok[0], 1'b0);
      nops(1);
      chk("R4", act_ok[0], 1'b1);
      step(3'd4, 0, 1);               // close the rest
      chk("R8", col_ok, 8'h00);
      nops(30);
      step(3'd4, 2, 0);               // precharge to idle bank
      chk("R9", err, 1'b0);
      chk("R9", act_ok[2], 1'b1);
      chk("R9", ref_ok, 1'b1);
      step(3'd5, 0, 0);
      chk("R10", err, 1'b0);

      // R12 saturation at 500 ps: tRAS gives 80 -> 63
      tck_ps = 16'd500;
      nops(2);
      step(3'd1, 1, 0);
      nops(61);
      chk("R12", pre_ok[1], 1'b0);
      nops(1);
      chk("R12", pre_ok[1], 1'b1);
      step(3'd4, 1, 0);
      nops(70);

      // R12 period 0 -> maximum count
      tck_ps = 16'd0;
      step(3'd1, 6, 0);
      nops(61);
      chk("R12", col_ok[6], 1'b0);
      nops(1);
      chk("R12", col_ok[6], 1'b1);
      step(3'd4, 6, 0);
      nops(70);

      // constrained random phases over several clock periods
      foreach (tcks[p]) begin
         tck_ps = 16'(tcks[p]);
         nops(70);
         for (int i = 0; i < 500; i++) begin
            int r = $urandom_range(0, 99);
            int b = ($urandom_range(0, 1) == 0) ? $urandom_range(0, 1) : $urandom_range(0, 7);
            bit ap = ($urandom_range(0, 3) == 0);
            logic [2:0] c;
            if      (r < 35) c = (r < 3) ? 3'd6 : 3'd0;
            else if (r < 55) c = 3'd1;
            else if (r < 65) c = 3'd2;
            else if (r < 75) c = 3'd3;
            else if (r < 92) c = 3'd4;
            else             c = 3'd5;
            step(c, b, ap);
         end
      end
      nops(2);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule